// File: doc/BRIEF.md
# Acquisition Card Bus Controller

This block is the control logic of a 16-channel, 12-bit acquisition card on a small-form-factor ISA-style I/O bus. It claims host I/O cycles addressed to its board, using a 10-bit port address and a base value set by jumpers. It keeps a channel number and a single-channel or scan mode written by the host. A start write launches a conversion run. The block pulses the converter's convert-start line, and each result is pushed into an external FIFO together with the channel it came from.

The host collects the samples by reading the data register. Each read returns the 12-bit result in the low bits and the channel tag in the top nibble, and removes one entry from the FIFO. When the FIFO drains after a run, the block raises an interrupt. The host can also poll a status register, which shows the empty flag and the pending interrupt. Reading the status register acknowledges the interrupt.

The bus strobes `iow_i` and `ior_i` are active high. They are synchronized inside the block, and the address and write data are held stable while a strobe is asserted.

Top module: `isa_acq_ctrl`

## Requirements
- R1: After reset, `convst_o`, `fifo_wr_o`, `fifo_rd_o`, `irq_o` and `data_oe_o` are low.
- R2: An access is claimed only when `addr_i[9]` is 1 and `addr_i[9:3]` equals `base_i`. `addr_i[2:0]` selects the register: 0 is data (read), 1 is start (write), 2 is control (write) and 3 is status (read). An address with `addr_i[9]` at 0 is ignored even if `addr_i[9:3]` equals `base_i`.
- R3: While `aen_i` is high, no access is claimed: a start write launches nothing and reads do not drive the bus.
- R4: `data_oe_o` is high only while a claimed read of offset 0 or offset 3 is in progress. Reads of offsets 1 and 2 leave the bus undriven.
- R5: A start write while idle produces conversion-start pulses on `convst_o`. Each pulse is exactly 2 clocks wide, and there is one pulse per conversion.
- R6: A control write stores the channel from `data_i[3:0]` and the mode from `data_i[4]` (0 = single, 1 = scan). In single mode a run makes one conversion of the stored channel. Each result is written to the FIFO as {channel[3:0], result[11:0]} with a one-clock `fifo_wr_o` pulse.
- R7: In scan mode a run converts channels 0 through 15 in ascending order, one conversion each, and then stops.
- R8: A data read returns {channel[3:0], result[11:0]} from the FIFO head and pops exactly one entry, at the end of the read strobe. When the FIFO is empty, a data read returns 0x0000 and pops nothing.
- R9: A start write that arrives while a run is in progress is ignored.
- R10: After a run ends, the next rise of `fifo_empty_i` sets `irq_o`. The status register reads as {bit 1 = interrupt pending, bit 0 = FIFO empty}, with the other bits at 0. A status read clears the pending interrupt when its strobe ends. If a new interrupt is set in the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Host I/O port address |
| aen_i | input | 1 | DMA address enable; blocks decoding while high |
| iow_i | input | 1 | Host write strobe, active high |
| ior_i | input | 1 | Host read strobe, active high |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Drive enable for the host data bus |
| base_i | input | 7 | Jumper-selected board base, compared with addr_i[9:3] |
| convst_o | output | 1 | Convert-start strobe to the converter |
| adc_done_i | input | 1 | One-clock pulse: conversion result valid |
| adc_data_i | input | 12 | Conversion result |
| fifo_wr_o | output | 1 | FIFO push strobe |
| fifo_wdata_o | output | 16 | FIFO push data {channel, result} |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| fifo_rdata_i | input | 16 | FIFO head entry |
| fifo_empty_i | input | 1 | FIFO empty flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The host read path and the conversion sequencer act at the same time during a scan. In that case a FIFO pop from a data read can land in the same clock as a push from a finishing conversion. A start write can also arrive while strobes are still being issued. The bench provokes both by starting a scan, sending a second start mid-run, and then draining the FIFO by polling status and data while conversions continue. It judges the result by the exact order of the channel tags and sample values read back, by the total count of 2-clock strobes, and by the interrupt rising only once the drained FIFO empties after the run has ended.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned OFS_DATA  = 0;
  localparam int unsigned OFS_START = 1;
  localparam int unsigned OFS_CTRL  = 2;
  localparam int unsigned OFS_STAT  = 3;
  localparam int unsigned MODE_BIT  = 4;

  typedef enum logic [1:0] {
    S_IDLE,
    S_STRB,
    S_WAIT
  } seq_state_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/acq_decode.sv
module acq_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OFS_W  = 3,
  localparam int unsigned BASE_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              hit_o,
  output logic [OFS_W-1:0]  ofs_o
);
  // expansion half of port space only, never during DMA
  assign hit_o = !aen_i && addr_i[ADDR_W-1] && (addr_i[ADDR_W-1:OFS_W] == base_i);
  assign ofs_o = addr_i[OFS_W-1:0];
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int unsigned CH_W     = 4,
  parameter int unsigned RES_W    = 12,
  parameter int unsigned STRB_LEN = 2,
  localparam int unsigned CNT_W   = $clog2(STRB_LEN) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  scan_i,
  input  logic [CH_W-1:0]       chan_i,
  input  logic                  adc_done_i,
  input  logic [RES_W-1:0]      adc_data_i,
  output logic                  convst_o,
  output logic                  wr_o,
  output logic [CH_W+RES_W-1:0] wdata_o,
  output logic                  busy_o,
  output logic                  done_o
);
  seq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  cur_q;
  logic             scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      scan_q  <= 1'b0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      wr_o   <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cur_q   <= scan_i ? '0 : chan_i;
          scan_q  <= scan_i;
          cnt_q   <= '0;
          state_q <= S_STRB;
        end
        S_STRB: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(STRB_LEN - 1)) state_q <= S_WAIT;
        end
        S_WAIT: if (adc_done_i) begin
          wr_o    <= 1'b1;
          wdata_o <= {cur_q, adc_data_i};
          if (scan_q && (cur_q != '1)) begin
            cur_q   <= cur_q + 1'b1;
            cnt_q   <= '0;
            state_q <= S_STRB;
          end else begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign convst_o = (state_q == S_STRB);
  assign busy_o   = (state_q != S_IDLE);
endmodule

// File: rtl/isa_acq_ctrl.sv
module isa_acq_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned OFS_W    = 3,
  parameter int unsigned CH_W     = 4,
  parameter int unsigned RES_W    = 12,
  parameter int unsigned STRB_LEN = 2,
  localparam int unsigned BUS_W   = CH_W + RES_W,
  localparam int unsigned BASE_W  = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              iow_i,
  input  logic              ior_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [BUS_W-1:0]  data_o,
  output logic              data_oe_o,
  input  logic [BASE_W-1:0] base_i,
  output logic              convst_o,
  input  logic              adc_done_i,
  input  logic [RES_W-1:0]  adc_data_i,
  output logic              fifo_wr_o,
  output logic [BUS_W-1:0]  fifo_wdata_o,
  output logic              fifo_rd_o,
  input  logic [BUS_W-1:0]  fifo_rdata_i,
  input  logic              fifo_empty_i,
  output logic              irq_o
);
  logic [1:0] strb_s;
  logic iow_s, ior_s, iow_q, ior_q;
  logic hit;
  logic [OFS_W-1:0] ofs;

  acq_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({iow_i, ior_i}),
    .q_o   (strb_s)
  );
  assign iow_s = strb_s[1];
  assign ior_s = strb_s[0];

  acq_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
    .addr_i(addr_i),
    .aen_i (aen_i),
    .base_i(base_i),
    .hit_o (hit),
    .ofs_o (ofs)
  );

  logic iow_rise, ior_rise, ior_fall;
  assign iow_rise = iow_s & ~iow_q;
  assign ior_rise = ior_s & ~ior_q;
  assign ior_fall = ~ior_s & ior_q;

  logic sel_data, sel_start, sel_ctrl, sel_stat;
  assign sel_data  = hit && (ofs == OFS_W'(OFS_DATA));
  assign sel_start = hit && (ofs == OFS_W'(OFS_START));
  assign sel_ctrl  = hit && (ofs == OFS_W'(OFS_CTRL));
  assign sel_stat  = hit && (ofs == OFS_W'(OFS_STAT));

  logic [CH_W-1:0] chan_q;
  logic            scan_q;
  logic            seq_start, seq_busy, seq_done;
  assign seq_start = iow_rise && sel_start;

  acq_seq #(.CH_W(CH_W), .RES_W(RES_W), .STRB_LEN(STRB_LEN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (seq_start),
    .scan_i    (scan_q),
    .chan_i    (chan_q),
    .adc_done_i(adc_done_i),
    .adc_data_i(adc_data_i),
    .convst_o  (convst_o),
    .wr_o      (fifo_wr_o),
    .wdata_o   (fifo_wdata_o),
    .busy_o    (seq_busy),
    .done_o    (seq_done)
  );

  logic unused_bits;
  assign unused_bits = ^{data_i[BUS_W-1:MODE_BIT+1], seq_busy};

  logic pop_arm, stat_arm, empty_q, armed_q, irq_q;
  logic irq_set;
  assign irq_set = armed_q && fifo_empty_i && !empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iow_q     <= 1'b0;
      ior_q     <= 1'b0;
      chan_q    <= '0;
      scan_q    <= 1'b0;
      pop_arm   <= 1'b0;
      stat_arm  <= 1'b0;
      fifo_rd_o <= 1'b0;
      empty_q   <= 1'b1;
      armed_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      iow_q     <= iow_s;
      ior_q     <= ior_s;
      empty_q   <= fifo_empty_i;
      fifo_rd_o <= 1'b0;
      if (iow_rise && sel_ctrl) begin
        chan_q <= data_i[CH_W-1:0];
        scan_q <= data_i[MODE_BIT];
      end
      // decode captured at strobe start, acted on at strobe end
      if (ior_rise) begin
        pop_arm  <= sel_data && !fifo_empty_i;
        stat_arm <= sel_stat;
      end
      if (ior_fall) begin
        fifo_rd_o <= pop_arm;
        pop_arm   <= 1'b0;
        stat_arm  <= 1'b0;
      end
      if (seq_start)     armed_q <= 1'b0;
      else if (seq_done) armed_q <= 1'b1;
      else if (irq_set)  armed_q <= 1'b0;
      if (irq_set)                    irq_q <= 1'b1;
      else if (ior_fall && stat_arm)  irq_q <= 1'b0;
    end
  end

  assign data_oe_o = ior_s && (sel_data || sel_stat);
  assign data_o = sel_data ? (fifo_empty_i ? '0 : fifo_rdata_i)
                           : {{(BUS_W-2){1'b0}}, irq_q, fifo_empty_i};
  assign irq_o = irq_q;
endmodule

// File: rtl/isa_acq_ctrl_chk.sv
module isa_acq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic convst_o,
  input logic fifo_wr_o,
  input logic fifo_rd_o,
  input logic fifo_empty_i,
  input logic irq_o,
  input logic data_oe_o,
  input logic ior_s
);
  p_strobe_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_o) |=> convst_o);
  p_strobe_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (convst_o && $past(convst_o)) |=> !convst_o);
  p_push_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |=> !fifo_wr_o);
  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);
  p_pop_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !fifo_rd_o);
  p_irq_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> fifo_empty_i);
  p_oe_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ior_s);
endmodule

bind isa_acq_ctrl isa_acq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .convst_o    (convst_o),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_rd_o   (fifo_rd_o),
  .fifo_empty_i(fifo_empty_i),
  .irq_o       (irq_o),
  .data_oe_o   (data_oe_o),
  .ior_s       (ior_s)
);

// File: tb/isa_acq_ctrl_test.sv
`timescale 1ns/1ps
module isa_acq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [9:0]  addr = '0;
  logic        aen = 1'b0, iow = 1'b0, ior = 1'b0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic        oe;
  logic [6:0]  base = 7'h5C;
  logic        convst, adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic        f_wr, f_rd, f_empty, irq;
  logic [15:0] f_wdata, f_rdata;

  isa_acq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .aen_i(aen), .iow_i(iow), .ior_i(ior),
    .data_i(wdat), .data_o(rdat), .data_oe_o(oe), .base_i(base), .convst_o(convst),
    .adc_done_i(adc_done), .adc_data_i(adc_data), .fifo_wr_o(f_wr), .fifo_wdata_o(f_wdata),
    .fifo_rd_o(f_rd), .fifo_rdata_i(f_rdata), .fifo_empty_i(f_empty), .irq_o(irq)
  );

  int tests = 0, fails = 0;

  function automatic logic [11:0] sval(int k);
    return 12'((k * 291 + 5) & 32'hFFF);
  endfunction

  // FIFO model
  logic [15:0] mem [64];
  int wp = 0, rp = 0, pops = 0;
  assign f_empty = (wp == rp);
  assign f_rdata = mem[rp % 64];
  always @(posedge clk) begin
    if (f_wr) begin mem[wp % 64] <= f_wdata; wp <= wp + 1; end
    if (f_rd) begin rp <= rp + 1; pops <= pops + 1; end
  end

  // converter model and strobe monitor
  logic cv_d = 1'b0;
  int cd = 0, k = 0, pulses = 0, run = 0, bad_w = 0;
  always @(posedge clk) begin
    cv_d <= convst;
    adc_done <= 1'b0;
    if (convst && !cv_d) begin cd <= 7; pulses <= pulses + 1; end
    else if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) begin adc_done <= 1'b1; adc_data <= sval(k); k <= k + 1; end
    end
    if (convst) run <= run + 1;
    else if (run != 0) begin
      if (run != 2) bad_w <= bad_w + 1;
      run <= 0;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic io_wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdat = d; iow = 1'b1;
    tick(6); iow = 1'b0; tick(4);
  endtask

  task automatic io_rd(logic [9:0] a, output logic [15:0] d, output logic e);
    @(negedge clk); addr = a; ior = 1'b1;
    tick(5); d = rdat; e = oe;
    ior = 1'b0; tick(5);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual 0x0000 expected 0x0001");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [15:0] d;
  logic e;
  int p0, guard;
  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    chk("R1 outputs idle", {11'b0, convst, f_wr, f_rd, irq, oe}, 16'h0);

    io_rd(10'h2E1, d, e); chk("R4 offset1 read undriven", {15'b0, e}, 16'h0);
    io_rd(10'h2E2, d, e); chk("R4 offset2 read undriven", {15'b0, e}, 16'h0);
    io_rd(10'h2E3, d, e); chk("R4 status read driven", {15'b0, e}, 16'h1);
    chk("R10 status idle", d, 16'h0001);

    io_wr(10'h2E9, 16'h0); tick(20); chk("R2 other board ignored", 16'(pulses), 16'h0);
    base = 7'h1C; io_wr(10'h0E1, 16'h0); tick(20);
    chk("R2 low half ignored", 16'(pulses), 16'h0);
    base = 7'h5C;

    aen = 1'b1; io_wr(10'h2E1, 16'h0); tick(20);
    chk("R3 dma write ignored", 16'(pulses), 16'h0);
    io_rd(10'h2E3, d, e); chk("R3 dma read undriven", {15'b0, e}, 16'h0);
    aen = 1'b0;

    io_wr(10'h2E2, 16'h0007);
    io_wr(10'h2E1, 16'h0); tick(40);
    chk("R5 single pulse count", 16'(pulses), 16'h1);
    chk("R6 single push count", 16'(wp), 16'h1);
    chk("R10 no irq while nonempty", {15'b0, irq}, 16'h0);
    io_rd(10'h2E0, d, e);
    chk("R6 single sample tag", d, {4'h7, sval(0)});
    chk("R8 one pop", 16'(pops), 16'h1);
    tick(3);
    chk("R10 irq after drain", {15'b0, irq}, 16'h1);
    io_rd(10'h2E3, d, e); chk("R10 status pending", d, 16'h0003);
    chk("R10 cleared by status read", {15'b0, irq}, 16'h0);
    io_rd(10'h2E3, d, e); chk("R10 status after clear", d, 16'h0001);

    io_rd(10'h2E0, d, e);
    chk("R8 empty read zero", d, 16'h0000);
    chk("R8 empty read no pop", 16'(pops), 16'h1);

    p0 = pulses;
    io_wr(10'h2E2, 16'h0015);
    io_wr(10'h2E1, 16'h0);
    tick(8);
    io_wr(10'h2E1, 16'h0);
    tick(20);
    for (int i = 0; i < 16; i++) begin
      guard = 0;
      do begin io_rd(10'h2E3, d, e); guard++; end while (d[0] && guard < 100);
      io_rd(10'h2E0, d, e);
      chk($sformatf("R7 scan sample %0d", i), d, {4'(i), sval(1 + i)});
    end
    tick(40);
    chk("R9 restart ignored", 16'(pulses - p0), 16'd16);
    chk("R5 strobe widths", 16'(bad_w), 16'h0);
    chk("R8 pops total", 16'(pops), 16'd17);
    chk("R10 irq after scan drain", {15'b0, irq}, 16'h1);
    io_rd(10'h2E3, d, e); chk("R10 status after scan", d, 16'h0003);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule